// File: doc/BRIEF.md
# Tag-Extending Request/Response Switch

This block concentrates `NUM_IN` upstream request ports onto `NUM_OUT` downstream ports, where `NUM_IN` is a whole multiple of `NUM_OUT` and the group size `R = NUM_IN/NUM_OUT` is a power of two. Upstream ports `o*R` to `o*R+R-1` share downstream port `o`. Within each group an arbiter picks one requester per cycle. The arbiter is either round robin or fixed priority, chosen by a parameter. Every channel uses a valid/ready handshake, and both paths are combinational from inputs to outputs.

The block keeps no table of outstanding requests. When a request goes downstream, the winner's local index is shifted into the low `L = log2(R)` bits of its tag. A response that comes back on downstream port `o` is steered to upstream port `o*R + (tag mod R)`. The tag is shifted right by `L` before delivery, which restores the original value. When the two port counts are equal, every lane is a direct wire from one port to the other.

Top module: `tag_switch`

## Requirements
- R1: A request accepted from local index i goes downstream with tag `(tag << L) | i`, zero-extended to `OUT_TAG_W`. It carries the winner's data unchanged.
- R2: A valid response on downstream port o with tag t is presented only on upstream port `o*R + (t mod R)`, with tag `t >> L` and the same data. A request therefore returns to its originating port with its original tag.
- R3: When `NUM_IN == NUM_OUT`, lane k connects straight through in both directions. Valid, ready, data and tag pass unchanged, with tags zero-extended going down and truncated coming back.
- R4: In round-robin mode, the search in each group starts at the pointer. After a grant is accepted, the pointer becomes the granted index plus 1, wrapping from R-1 to 0.
- R5: In fixed-priority mode, the lowest valid local index always wins.
- R6: Each downstream port accepts at most one request per cycle. Only the winner sees ready, and only while its downstream ready is high.
- R7: Downstream response ready equals the ready of the selected upstream port. The response path does not depend on the request path.
- R8: Reset (active-low `rstN`) sets every arbitration pointer to 0. After reset, the first grant goes to the lowest valid index.
- R9: A downstream request valid is high exactly when some upstream port of its group is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| upReqValid | input | NUM_IN | Upstream request valid |
| upReqReady | output | NUM_IN | Upstream request ready |
| upReqTag | input | NUM_IN*TAG_W | Upstream request tags |
| upReqData | input | NUM_IN*DATA_W | Upstream request payloads |
| dnReqValid | output | NUM_OUT | Downstream request valid |
| dnReqReady | input | NUM_OUT | Downstream request ready |
| dnReqTag | output | NUM_OUT*OUT_TAG_W | Extended downstream tags |
| dnReqData | output | NUM_OUT*DATA_W | Downstream payloads |
| dnRspValid | input | NUM_OUT | Downstream response valid |
| dnRspReady | output | NUM_OUT | Downstream response ready |
| dnRspTag | input | NUM_OUT*OUT_TAG_W | Extended response tags |
| dnRspData | input | NUM_OUT*DATA_W | Response payloads |
| upRspValid | output | NUM_IN | Upstream response valid |
| upRspReady | input | NUM_IN | Upstream response ready |
| upRspTag | output | NUM_IN*TAG_W | Restored response tags |
| upRspData | output | NUM_IN*DATA_W | Response payloads |

## Verification
The assertions check the following on every cycle:
- the tag extension and data carried on each accepted request;
- response steering and tag restoration;
- single acceptance per group;
- valid aggregation and response ready;
- the round-robin step from one grant to the next index.

The bench's reference model tracks its own pointers. Its scenarios show the grant order under constant contention, the fixed-priority winner, and the bypass wiring. They also show that each response sent back with a recorded downstream tag lands on the port that issued it, carrying the original tag.

// File: rtl/tsw_pkg.sv
package tsw_pkg;
  localparam int MAX_PORTS = 32;
  localparam int IDX_W = 5;

  // strobes from a group arbiter to its datapath
  typedef struct packed {
    logic             anyReq;
    logic             fire;
    logic [IDX_W-1:0] grantIdx;
  } arb_ctrl_t;
endpackage

// File: rtl/tsw_ctrl.sv
module tsw_ctrl
  import tsw_pkg::*;
#(
  parameter int R = 4,
  parameter bit ROUND_ROBIN = 1'b1
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [R-1:0] reqValid,
  input  logic         downReady,
  output arb_ctrl_t    ctrl
);
  localparam int PW = (R > 1) ? $clog2(R) : 1;

  logic [PW-1:0] ptr;
  logic          found;
  int            winIdx;

  always_comb begin
    found  = 1'b0;
    winIdx = 0;
    for (int r = 0; r < R; r++) begin
      int cand;
      cand = (int'(ptr) + r) % R;
      if (!found && reqValid[cand]) begin
        found  = 1'b1;
        winIdx = cand;
      end
    end
    ctrl.anyReq   = found;
    ctrl.fire     = found && downReady;
    ctrl.grantIdx = IDX_W'(winIdx);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ptr <= '0;
    else if (ROUND_ROBIN && ctrl.fire)
      ptr <= (winIdx == R - 1) ? '0 : PW'(winIdx + 1);
  end
endmodule

// File: rtl/tsw_dpath.sv
module tsw_dpath
  import tsw_pkg::*;
#(
  parameter int R = 4,
  parameter int L = 2,
  parameter int TAG_W = 6,
  parameter int OUT_TAG_W = 8,
  parameter int DATA_W = 8
) (
  input  arb_ctrl_t              ctrl,
  input  logic [R*TAG_W-1:0]     grpReqTag,
  input  logic [R*DATA_W-1:0]    grpReqData,
  output logic [R-1:0]           grpReqReady,
  output logic                   downValid,
  output logic [OUT_TAG_W-1:0]   downTag,
  output logic [DATA_W-1:0]      downData,
  input  logic                   rspValid,
  input  logic [OUT_TAG_W-1:0]   rspTag,
  input  logic [DATA_W-1:0]      rspData,
  output logic                   rspReady,
  output logic [R-1:0]           grpRspValid,
  output logic [R*TAG_W-1:0]     grpRspTag,
  output logic [R*DATA_W-1:0]    grpRspData,
  input  logic [R-1:0]           grpRspReady
);
  int gi;
  int ri;
  logic [OUT_TAG_W-1:0] restored;

  // request side: mux the winner and append its index
  always_comb begin
    gi          = int'(ctrl.grantIdx);
    downValid   = ctrl.anyReq;
    downData    = grpReqData[gi*DATA_W +: DATA_W];
    downTag     = (OUT_TAG_W'(grpReqTag[gi*TAG_W +: TAG_W]) << L) | OUT_TAG_W'(gi);
    grpReqReady = '0;
    grpReqReady[gi] = ctrl.fire;
  end

  // response side: low tag bits pick the port, shift restores tag
  always_comb begin
    ri          = (R > 1) ? (int'(rspTag) & (R - 1)) : 0;
    restored    = rspTag >> L;
    grpRspValid = '0;
    grpRspValid[ri] = rspValid;
    rspReady    = grpRspReady[ri];
    for (int k = 0; k < R; k++) begin
      grpRspTag[k*TAG_W +: TAG_W]    = restored[TAG_W-1:0];
      grpRspData[k*DATA_W +: DATA_W] = rspData;
    end
  end
endmodule

// File: rtl/tag_switch.sv
module tag_switch
  import tsw_pkg::*;
#(
  parameter int NUM_IN = 8,
  parameter int NUM_OUT = 2,
  parameter int TAG_W = 6,
  parameter int OUT_TAG_W = 8,
  parameter int DATA_W = 8,
  parameter bit ROUND_ROBIN = 1'b1
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [NUM_IN-1:0]            upReqValid,
  output logic [NUM_IN-1:0]            upReqReady,
  input  logic [NUM_IN*TAG_W-1:0]      upReqTag,
  input  logic [NUM_IN*DATA_W-1:0]     upReqData,
  output logic [NUM_OUT-1:0]           dnReqValid,
  input  logic [NUM_OUT-1:0]           dnReqReady,
  output logic [NUM_OUT*OUT_TAG_W-1:0] dnReqTag,
  output logic [NUM_OUT*DATA_W-1:0]    dnReqData,
  input  logic [NUM_OUT-1:0]           dnRspValid,
  output logic [NUM_OUT-1:0]           dnRspReady,
  input  logic [NUM_OUT*OUT_TAG_W-1:0] dnRspTag,
  input  logic [NUM_OUT*DATA_W-1:0]    dnRspData,
  output logic [NUM_IN-1:0]            upRspValid,
  input  logic [NUM_IN-1:0]            upRspReady,
  output logic [NUM_IN*TAG_W-1:0]      upRspTag,
  output logic [NUM_IN*DATA_W-1:0]     upRspData
);
  localparam int R = NUM_IN / NUM_OUT;
  localparam int L = (R > 1) ? $clog2(R) : 0;

  initial begin
    if (NUM_IN > MAX_PORTS || NUM_OUT > MAX_PORTS || NUM_OUT < 1 ||
        NUM_IN % NUM_OUT != 0 || (R & (R - 1)) != 0 || TAG_W + L > OUT_TAG_W)
      $fatal(1, "tag_switch: illegal parameter set");
  end

  if (NUM_IN == NUM_OUT) begin : g_bypass
    for (genvar k = 0; k < NUM_IN; k++) begin : g_lane
      assign dnReqValid[k] = upReqValid[k];
      assign upReqReady[k] = dnReqReady[k];
      assign dnReqTag[k*OUT_TAG_W +: OUT_TAG_W] = OUT_TAG_W'(upReqTag[k*TAG_W +: TAG_W]);
      assign dnReqData[k*DATA_W +: DATA_W] = upReqData[k*DATA_W +: DATA_W];
      assign upRspValid[k] = dnRspValid[k];
      assign dnRspReady[k] = upRspReady[k];
      assign upRspTag[k*TAG_W +: TAG_W] = dnRspTag[k*OUT_TAG_W +: TAG_W];
      assign upRspData[k*DATA_W +: DATA_W] = dnRspData[k*DATA_W +: DATA_W];
    end
  end else begin : g_switch
    for (genvar o = 0; o < NUM_OUT; o++) begin : g_grp
      arb_ctrl_t ctrl;

      tsw_ctrl #(.R(R), .ROUND_ROBIN(ROUND_ROBIN)) u_ctrl (
        .clk      (clk),
        .rstN     (rstN),
        .reqValid (upReqValid[o*R +: R]),
        .downReady(dnReqReady[o]),
        .ctrl     (ctrl)
      );

      tsw_dpath #(
        .R(R), .L(L), .TAG_W(TAG_W), .OUT_TAG_W(OUT_TAG_W), .DATA_W(DATA_W)
      ) u_dpath (
        .ctrl       (ctrl),
        .grpReqTag  (upReqTag[o*R*TAG_W +: R*TAG_W]),
        .grpReqData (upReqData[o*R*DATA_W +: R*DATA_W]),
        .grpReqReady(upReqReady[o*R +: R]),
        .downValid  (dnReqValid[o]),
        .downTag    (dnReqTag[o*OUT_TAG_W +: OUT_TAG_W]),
        .downData   (dnReqData[o*DATA_W +: DATA_W]),
        .rspValid   (dnRspValid[o]),
        .rspTag     (dnRspTag[o*OUT_TAG_W +: OUT_TAG_W]),
        .rspData    (dnRspData[o*DATA_W +: DATA_W]),
        .rspReady   (dnRspReady[o]),
        .grpRspValid(upRspValid[o*R +: R]),
        .grpRspTag  (upRspTag[o*R*TAG_W +: R*TAG_W]),
        .grpRspData (upRspData[o*R*DATA_W +: R*DATA_W]),
        .grpRspReady(upRspReady[o*R +: R])
      );
    end
  end
endmodule

// File: rtl/tag_switch_chk.sv
module tag_switch_chk #(
  parameter int NUM_IN = 8,
  parameter int NUM_OUT = 2,
  parameter int TAG_W = 6,
  parameter int OUT_TAG_W = 8,
  parameter int DATA_W = 8,
  parameter bit ROUND_ROBIN = 1'b1
) (
  input logic                         clk,
  input logic                         rstN,
  input logic [NUM_IN-1:0]            upReqValid,
  input logic [NUM_IN-1:0]            upReqReady,
  input logic [NUM_IN*TAG_W-1:0]      upReqTag,
  input logic [NUM_IN*DATA_W-1:0]     upReqData,
  input logic [NUM_OUT-1:0]           dnReqValid,
  input logic [NUM_OUT-1:0]           dnReqReady,
  input logic [NUM_OUT*OUT_TAG_W-1:0] dnReqTag,
  input logic [NUM_OUT*DATA_W-1:0]    dnReqData,
  input logic [NUM_OUT-1:0]           dnRspValid,
  input logic [NUM_OUT-1:0]           dnRspReady,
  input logic [NUM_OUT*OUT_TAG_W-1:0] dnRspTag,
  input logic [NUM_OUT*DATA_W-1:0]    dnRspData,
  input logic [NUM_IN-1:0]            upRspValid,
  input logic [NUM_IN-1:0]            upRspReady,
  input logic [NUM_IN*TAG_W-1:0]      upRspTag,
  input logic [NUM_IN*DATA_W-1:0]     upRspData
);
  localparam int R = NUM_IN / NUM_OUT;
  localparam int L = (R > 1) ? $clog2(R) : 0;

  for (genvar o = 0; o < NUM_OUT; o++) begin : g_o
    // R6: one acceptance per downstream port
    a_r6_one_grant: assert property (@(posedge clk) disable iff (!rstN)
      $countones(upReqValid[o*R +: R] & upReqReady[o*R +: R]) <= 1);
    // R9: valid aggregation
    a_r9_valid_any: assert property (@(posedge clk) disable iff (!rstN)
      dnReqValid[o] == (|upReqValid[o*R +: R]));
    // R7: response ready follows selected upstream port
    a_r7_rsp_ready: assert property (@(posedge clk) disable iff (!rstN)
      dnRspValid[o] |-> dnRspReady[o] == (|(upRspValid[o*R +: R] & upRspReady[o*R +: R])));

    for (genvar r = 0; r < R; r++) begin : g_r
      localparam int J  = o * R + r;
      localparam int JN = o * R + ((r + 1) % R);
      // R1: accepted request tag carries the local index
      a_r1_tag_extend: assert property (@(posedge clk) disable iff (!rstN)
        (upReqValid[J] && upReqReady[J]) |->
          (dnReqTag[o*OUT_TAG_W +: OUT_TAG_W] ==
             ((OUT_TAG_W'(upReqTag[J*TAG_W +: TAG_W]) << L) | OUT_TAG_W'(r)) &&
           dnReqData[o*DATA_W +: DATA_W] == upReqData[J*DATA_W +: DATA_W]));
      // R2: response steering and restored tag
      a_r2_rsp_route: assert property (@(posedge clk) disable iff (!rstN)
        (dnRspValid[o] && ((int'(dnRspTag[o*OUT_TAG_W +: OUT_TAG_W]) % R) == r)) |->
          (upRspValid[J] &&
           upRspTag[J*TAG_W +: TAG_W] == TAG_W'(dnRspTag[o*OUT_TAG_W +: OUT_TAG_W] >> L) &&
           upRspData[J*DATA_W +: DATA_W] == dnRspData[o*DATA_W +: DATA_W]));
      if (ROUND_ROBIN) begin : g_rr
        // R4: next grant after index r starts at r+1
        a_r4_rr_step: assert property (@(posedge clk) disable iff (!rstN)
          ($past(upReqValid[J] && upReqReady[J]) && upReqValid[JN] && dnReqReady[o]) |->
            upReqReady[JN]);
      end
    end
  end
endmodule

bind tag_switch tag_switch_chk #(
  .NUM_IN(NUM_IN), .NUM_OUT(NUM_OUT), .TAG_W(TAG_W), .OUT_TAG_W(OUT_TAG_W),
  .DATA_W(DATA_W), .ROUND_ROBIN(ROUND_ROBIN)
) u_chk (
  .clk(clk), .rstN(rstN),
  .upReqValid(upReqValid), .upReqReady(upReqReady), .upReqTag(upReqTag), .upReqData(upReqData),
  .dnReqValid(dnReqValid), .dnReqReady(dnReqReady), .dnReqTag(dnReqTag), .dnReqData(dnReqData),
  .dnRspValid(dnRspValid), .dnRspReady(dnRspReady), .dnRspTag(dnRspTag), .dnRspData(dnRspData),
  .upRspValid(upRspValid), .upRspReady(upRspReady), .upRspTag(upRspTag), .upRspData(upRspData)
);

// File: tb/tag_switch_bench.sv
`timescale 1ns/1ps
module tag_switch_bench;
  localparam int NI = 8, NO = 2, R = 4, L = 2, TW = 6, OTW = 8, DW = 8, NB = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2.5 clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  logic [NI-1:0] reqV = '0, upRdy = '0;
  logic [NI*TW-1:0] reqT = '0;
  logic [NI*DW-1:0] reqD = '0;
  logic [NO-1:0] dnRdy = '0, rspV = '0;
  logic [NO*OTW-1:0] rspT = '0;
  logic [NO*DW-1:0] rspD = '0;

  logic [NI-1:0] rrReqRdy, rrUpV, pReqRdy, pUpV;
  logic [NO-1:0] rrDnV, rrRspRdy, pDnV, pRspRdy;
  logic [NO*OTW-1:0] rrDnT, pDnT;
  logic [NO*DW-1:0] rrDnD, pDnD;
  logic [NI*TW-1:0] rrUpT, pUpT;
  logic [NI*DW-1:0] rrUpD, pUpD;

  tag_switch u_tag_switch (
    .clk(clk), .rstN(rstN),
    .upReqValid(reqV), .upReqReady(rrReqRdy), .upReqTag(reqT), .upReqData(reqD),
    .dnReqValid(rrDnV), .dnReqReady(dnRdy), .dnReqTag(rrDnT), .dnReqData(rrDnD),
    .dnRspValid(rspV), .dnRspReady(rrRspRdy), .dnRspTag(rspT), .dnRspData(rspD),
    .upRspValid(rrUpV), .upRspReady(upRdy), .upRspTag(rrUpT), .upRspData(rrUpD));

  tag_switch #(.ROUND_ROBIN(1'b0)) u_tag_switch_prio (
    .clk(clk), .rstN(rstN),
    .upReqValid(reqV), .upReqReady(pReqRdy), .upReqTag(reqT), .upReqData(reqD),
    .dnReqValid(pDnV), .dnReqReady(dnRdy), .dnReqTag(pDnT), .dnReqData(pDnD),
    .dnRspValid(rspV), .dnRspReady(pRspRdy), .dnRspTag(rspT), .dnRspData(rspD),
    .upRspValid(pUpV), .upRspReady(upRdy), .upRspTag(pUpT), .upRspData(pUpD));

  logic [NB-1:0] bRdy = '0, bRspV = '0, bReqRdy, bDnV, bRspRdy, bUpV, bUpRdy = '0;
  logic [NB*OTW-1:0] bDnT, bRspT = '0;
  logic [NB*DW-1:0] bDnD, bRspD = '0, bUpD;
  logic [NB*TW-1:0] bUpT;

  tag_switch #(.NUM_IN(NB), .NUM_OUT(NB)) u_tag_switch_byp (
    .clk(clk), .rstN(rstN),
    .upReqValid(reqV[NB-1:0]), .upReqReady(bReqRdy), .upReqTag(reqT[NB*TW-1:0]),
    .upReqData(reqD[NB*DW-1:0]),
    .dnReqValid(bDnV), .dnReqReady(bRdy), .dnReqTag(bDnT), .dnReqData(bDnD),
    .dnRspValid(bRspV), .dnRspReady(bRspRdy), .dnRspTag(bRspT), .dnRspData(bRspD),
    .upRspValid(bUpV), .upRspReady(bUpRdy), .upRspTag(bUpT), .upRspData(bUpD));

  int ptr[NO];
  int qTag[NO][$];
  int qSrc[NO][$];
  int qOrig[NO][$];

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int pick(int o, int start);
    for (int r = 0; r < R; r++) begin
      int c;
      c = (start + r) % R;
      if (reqV[o*R + c]) return c;
    end
    return -1;
  endfunction

  task automatic checkCycle();
    for (int o = 0; o < NO; o++) begin
      int w, wp;
      logic [NI-1:0] expRdy, expRdyP;
      w = pick(o, ptr[o]);
      wp = pick(o, 0);
      chk(rrDnV[o] == (w >= 0), "R9 dn valid", rrDnV[o], w >= 0);
      expRdy = '0;
      expRdyP = '0;
      if (w >= 0 && dnRdy[o]) expRdy[o*R + w] = 1'b1;
      if (wp >= 0 && dnRdy[o]) expRdyP[o*R + wp] = 1'b1;
      chk(rrReqRdy[o*R +: R] == expRdy[o*R +: R], "R4/R6 rr grant", rrReqRdy[o*R +: R], expRdy[o*R +: R]);
      chk(pReqRdy[o*R +: R] == expRdyP[o*R +: R], "R5 prio grant", pReqRdy[o*R +: R], expRdyP[o*R +: R]);
      if (w >= 0) begin
        longint et;
        et = reqT[(o*R + w)*TW +: TW] * R + w;
        chk(rrDnT[o*OTW +: OTW] == et, "R1 tag extend", rrDnT[o*OTW +: OTW], et);
        chk(rrDnD[o*DW +: DW] == reqD[(o*R + w)*DW +: DW], "R1 data", rrDnD[o*DW +: DW],
            reqD[(o*R + w)*DW +: DW]);
        if (dnRdy[o]) begin
          qTag[o].push_back(int'(et));
          qSrc[o].push_back(o*R + w);
          qOrig[o].push_back(int'(reqT[(o*R + w)*TW +: TW]));
          ptr[o] = (w + 1) % R;
        end
      end
      if (rspV[o]) begin
        int s, ot;
        logic [NI-1:0] ev;
        s = qSrc[o][0];
        ot = qOrig[o][0];
        ev = '0;
        ev[s] = 1'b1;
        chk(rrUpV[o*R +: R] == ev[o*R +: R], "R2 rsp steer", rrUpV[o*R +: R], ev[o*R +: R]);
        chk(rrUpT[s*TW +: TW] == ot, "R2 original tag", rrUpT[s*TW +: TW], ot);
        chk(rrUpD[s*DW +: DW] == rspD[o*DW +: DW], "R2 rsp data", rrUpD[s*DW +: DW], rspD[o*DW +: DW]);
        chk(rrRspRdy[o] == upRdy[s], "R7 rsp ready", rrRspRdy[o], upRdy[s]);
        chk(pRspRdy[o] == upRdy[s] && pUpV == rrUpV, "R7 rsp path mode-independent", pRspRdy[o], upRdy[s]);
        if (upRdy[s]) begin
          void'(qTag[o].pop_front());
          void'(qSrc[o].pop_front());
          void'(qOrig[o].pop_front());
        end
      end else begin
        chk(rrUpV[o*R +: R] == '0, "R2 no rsp", rrUpV[o*R +: R], 0);
      end
    end
    chk(bDnV == reqV[NB-1:0] && bReqRdy == bRdy && bUpV == bRspV && bRspRdy == bUpRdy,
        "R3 bypass handshake", {bDnV, bReqRdy, bUpV, bRspRdy}, {reqV[NB-1:0], bRdy, bRspV, bUpRdy});
    for (int k = 0; k < NB; k++) begin
      chk(bDnT[k*OTW +: OTW] == OTW'(reqT[k*TW +: TW]) && bUpT[k*TW +: TW] == bRspT[k*OTW +: TW] &&
          bDnD[k*DW +: DW] == reqD[k*DW +: DW] && bUpD[k*DW +: DW] == bRspD[k*DW +: DW],
          "R3 bypass lane", bDnT[k*OTW +: OTW], reqT[k*TW +: TW]);
    end
  endtask

  task automatic drive(input int cyc, input bit allOn);
    reqV = allOn ? '1 : NI'($urandom);
    for (int j = 0; j < NI; j++) begin
      reqT[j*TW +: TW] = TW'(cyc * 7 + j * 9);
      reqD[j*DW +: DW] = DW'($urandom);
    end
    dnRdy = allOn ? '1 : NO'($urandom);
    upRdy = NI'($urandom);
    for (int o = 0; o < NO; o++) begin
      rspV[o] = (qTag[o].size() > 0) && ($urandom % 3 != 0);
      rspT[o*OTW +: OTW] = (qTag[o].size() > 0) ? OTW'(qTag[o][0]) : '0;
      rspD[o*DW +: DW] = DW'($urandom);
    end
    bRdy = NB'($urandom);
    bRspV = NB'($urandom);
    bUpRdy = NB'($urandom);
    bRspT = (NB*OTW)'({$urandom, $urandom});
    bRspD = (NB*DW)'($urandom);
  endtask

  initial begin
    for (int o = 0; o < NO; o++) ptr[o] = 0;
    repeat (3) @(negedge clk);
    #1;
    chk(rrDnV == '0 && rrReqRdy == '0, "R8 reset idle", {rrDnV, rrReqRdy}, 0);
    @(negedge clk);
    rstN = 1'b1;
    // R8: first grant after reset with all valid goes to index 0
    @(negedge clk);
    drive(0, 1'b1);
    #1;
    chk(rrReqRdy == 8'b0001_0001, "R8 first grant", rrReqRdy, 8'b0001_0001);
    checkCycle();
    // R4 directed rotation under constant contention, then random traffic
    for (int c = 1; c < 3000; c++) begin
      @(negedge clk);
      drive(c, c < 12);
      #1;
      checkCycle();
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule